// File: doc/BRIEF.md
# Dual-Mode SPI Serial Port

An 8-bit serial port that runs either as bus master or as a selected slave. A single shift register holds the outgoing byte. During a transfer, the incoming bits replace it, so at the end the same buffer holds the byte that arrived. A status flag reports a full receive buffer, and reading the buffer clears it.

In master mode the port makes its own serial clock from the system clock. The divisor is chosen by a 3-bit rate field. The port drives an active-low select for the whole byte, and a control bit chooses which clock edge launches data and which edge samples it. Writing the buffer while the port is idle starts a transfer.

In slave mode the clock and select come from outside. They pass through a two-flop synchronizer, so the system clock must run at four times the serial clock or faster. In this mode the edge bit and the rate field do nothing. The slave always samples on the rising clock edge and changes its output on the falling edge. The data output is released whenever the select input is high.

Top module: `spi_port`

## Requirements
- R1: After reset the buffer reads 0x00, the full flag and busy are low, the select output is high, the clock output is low, and both output enables are low (the control register resets to 0, which is slave mode).
- R2: The control word is {master, edge_sel, rate[2:0]} (bit 4 = master). In master mode, a buffer write while idle starts a transfer. Busy rises and the peer receives the written byte, most significant bit first.
- R3: When a transfer completes, the buffer holds the received byte and the full flag is set in the same cycle that busy falls.
- R4: In master mode the serial clock period is 2^(rate+1) system clock cycles, and the clock rests low whenever the select output is high.
- R5: With edge_sel = 0 the master samples its input on the rising clock edge and changes its output on the falling edge. With edge_sel = 1 it does the reverse.
- R6: A buffer write during a master transfer is ignored. It changes neither the byte sent nor the byte received.
- R7: Reading the buffer clears the full flag. The flag stays set until it is read.
- R8: In slave mode the port shifts one byte on the external clock while select is low, sampling on rising edges. The edge bit and the rate field have no effect.
- R9: In slave mode, while the select input is high, the data output enable is low and clock or data activity changes neither the buffer nor the flag.
- R10: A slave transfer ended by select going high before the eighth sampling edge does not set the full flag, and it restores the byte that was loaded.
- R11: In master mode the select output is low from the start of a transfer until after the last clock edge, and high when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 5 | Control word {master, edge_sel, rate[2:0]} |
| buf_we_i | input | 1 | Data buffer write strobe |
| buf_wdata_i | input | 8 | Byte to transmit |
| buf_re_i | input | 1 | Data buffer read strobe, clears full flag |
| buf_rdata_o | output | 8 | Data buffer contents |
| full_o | output | 1 | Receive buffer full |
| busy_o | output | 1 | Transfer in progress |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe_o | output | 1 | Serial clock output enable (master mode) |
| sck_i | input | 1 | Serial clock from external master |
| ss_no | output | 1 | Slave select driven in master mode, active low |
| ss_ni | input | 1 | Slave select from external master, active low |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Serial data output enable |
| sdi_i | input | 1 | Serial data in |

## Verification
A wrong bit counter or edge decode shows up at the end of a byte. The byte left in the buffer or the byte the peer captured comes out shifted or reversed, and the full flag rises one half-period early or late. A bad rate divisor shows up within the first two clock edges as a wrong period. A stuck select or output enable is visible the same cycle the slave select input rises. An aborted slave transfer leaves a corrupted buffer or a set flag as soon as select returns high.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int unsigned BAUD_W = 3;

  typedef struct packed {
    logic              master;
    logic              edge_sel;
    logic [BAUD_W-1:0] baud;
  } spi_ctrl_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned    W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= {2{RST_VAL[i]}};
      else         ff_q <= {ff_q[0], d_i[i]};
    end
    assign q_o[i] = ff_q[1];
  end
endmodule

// File: rtl/spi_master_seq.sv
module spi_master_seq #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BAUD_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              edge_sel_i,
  input  logic [BAUD_W-1:0] baud_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              sample_o,
  output logic              launch_o,
  output logic              done_o
);
  localparam int unsigned CNT_W  = 2**BAUD_W;
  localparam int unsigned EDGES  = 2*DATA_W;
  localparam int unsigned EDGE_W = $clog2(EDGES+1);

  logic [CNT_W-1:0]  cnt_q, half_lim;
  logic [EDGE_W-1:0] edge_q;
  logic [BAUD_W-1:0] baud_q;
  logic              pol_q, busy_q, sck_q;
  logic              tick, last, rise, fall;

  // half period = 2^baud system cycles
  assign half_lim = (CNT_W'(1) << baud_q) - CNT_W'(1);
  assign tick     = busy_q && (cnt_q == half_lim);
  assign last     = (edge_q == EDGE_W'(EDGES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      edge_q <= '0;
      baud_q <= '0;
      pol_q  <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        edge_q <= '0;
        baud_q <= baud_i;
        pol_q  <= edge_sel_i;
      end
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick) begin
        if (last) begin
          busy_q <= 1'b0;
        end else begin
          sck_q  <= ~sck_q;
          edge_q <= edge_q + 1'b1;
        end
      end
    end
  end

  assign rise     = tick && !last && !sck_q;
  assign fall     = tick && !last &&  sck_q;
  assign sample_o = pol_q ? fall : rise;
  assign launch_o = pol_q ? rise : fall;
  assign done_o   = tick && last;
  assign busy_o   = busy_q;
  assign sck_o    = sck_q;
endmodule

// File: rtl/spi_slave_seq.sv
module spi_slave_seq #(
  parameter int unsigned DATA_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sck_i,
  input  logic ss_n_i,
  output logic active_o,
  output logic start_o,
  output logic sample_o,
  output logic launch_o,
  output logic done_o,
  output logic abort_o
);
  localparam int unsigned BIT_W = $clog2(DATA_W);

  logic             sck_d, active_q, done_q;
  logic [BIT_W-1:0] bit_q;
  logic             rise, fall, live;

  assign rise     = sck_i && !sck_d;
  assign fall     = !sck_i && sck_d;
  assign live     = active_q && !ss_n_i && !done_q;
  assign start_o  = en_i && !ss_n_i && !active_q;
  assign sample_o = live && rise;
  assign launch_o = live && fall;
  assign done_o   = sample_o && (bit_q == BIT_W'(DATA_W-1));
  assign abort_o  = active_q && ss_n_i && !done_q;
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d    <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      bit_q    <= '0;
    end else begin
      sck_d <= sck_i;
      if (start_o) begin
        active_q <= 1'b1;
        done_q   <= 1'b0;
        bit_q    <= '0;
      end else if (active_q && ss_n_i) begin
        active_q <= 1'b0;
      end else if (sample_o) begin
        bit_q <= bit_q + 1'b1;
        if (done_o) done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       ctrl_we_i,
  input  logic [$bits(spi_port_pkg::spi_ctrl_t)-1:0] ctrl_wdata_i,
  input  logic                                       buf_we_i,
  input  logic [DATA_W-1:0]                          buf_wdata_i,
  input  logic                                       buf_re_i,
  output logic [DATA_W-1:0]                          buf_rdata_o,
  output logic                                       full_o,
  output logic                                       busy_o,
  output logic                                       sck_o,
  output logic                                       sck_oe_o,
  input  logic                                       sck_i,
  output logic                                       ss_no,
  input  logic                                       ss_ni,
  output logic                                       sdo_o,
  output logic                                       sdo_oe_o,
  input  logic                                       sdi_i
);
  import spi_port_pkg::*;

  localparam int unsigned MSB = DATA_W - 1;

  spi_ctrl_t         ctrl_q;
  logic [DATA_W-1:0] sr_q, hold_q;
  logic              out_q, full_q;
  logic              sck_s, ss_s, sdi_s;
  logic              m_busy, m_sck, m_sample, m_launch, m_done;
  logic              s_active, s_start, s_sample, s_launch, s_done, s_abort;
  logic              mode_m, m_start, s_load, load;
  logic              sample, launch, done, in_bit, xfer_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= spi_ctrl_t'(ctrl_wdata_i);
  end

  assign mode_m = ctrl_q.master;

  spi_sync #(.W(3), .RST_VAL(3'b010)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, ss_ni, sdi_i}),
    .q_o   ({sck_s, ss_s, sdi_s})
  );

  spi_master_seq #(.DATA_W(DATA_W), .BAUD_W(BAUD_W)) i_master (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (m_start),
    .edge_sel_i(ctrl_q.edge_sel),
    .baud_i    (ctrl_q.baud),
    .busy_o    (m_busy),
    .sck_o     (m_sck),
    .sample_o  (m_sample),
    .launch_o  (m_launch),
    .done_o    (m_done)
  );

  spi_slave_seq #(.DATA_W(DATA_W)) i_slave (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (!mode_m),
    .sck_i   (sck_s),
    .ss_n_i  (ss_s),
    .active_o(s_active),
    .start_o (s_start),
    .sample_o(s_sample),
    .launch_o(s_launch),
    .done_o  (s_done),
    .abort_o (s_abort)
  );

  assign m_start   = mode_m && buf_we_i && !m_busy;
  assign s_load    = !mode_m && buf_we_i && !s_active && !s_start;
  assign load      = m_start || s_load;
  assign sample    = mode_m ? m_sample : s_sample;
  assign launch    = mode_m ? m_launch : s_launch;
  assign done      = mode_m ? m_done   : s_done;
  assign in_bit    = mode_m ? sdi_i    : sdi_s;
  assign xfer_busy = mode_m ? m_busy   : s_active;

  // shared transmit/receive shift register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      hold_q <= '0;
      out_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      if (s_start && !mode_m) hold_q <= sr_q;

      if (load)                   sr_q <= buf_wdata_i;
      else if (!mode_m && s_abort) sr_q <= hold_q;
      else if (sample)            sr_q <= {sr_q[MSB-1:0], in_bit};

      if (load)            out_q <= buf_wdata_i[MSB];
      else if (launch)     out_q <= sr_q[MSB];
      else if (!xfer_busy) out_q <= sr_q[MSB];

      if (done)          full_q <= 1'b1;
      else if (buf_re_i) full_q <= 1'b0;
    end
  end

  assign buf_rdata_o = sr_q;
  assign full_o      = full_q;
  assign busy_o      = xfer_busy;
  assign sck_o       = m_sck;
  assign sck_oe_o    = mode_m;
  assign ss_no       = !(mode_m && m_busy);
  assign sdo_o       = out_q;
  assign sdo_oe_o    = mode_m ? 1'b1 : !ss_ni;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic master_i,
  input logic busy_i,
  input logic full_i,
  input logic buf_re_i,
  input logic sck_i,
  input logic ss_n_i,
  input logic ss_ext_ni
);
  assert_sck_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_n_i |-> !sck_i);

  assert_sck_framed_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_i != $past(sck_i)) |-> (!ss_n_i && !$past(ss_n_i)));

  assert_full_at_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $fell(busy_i)) |-> full_i);

  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && buf_re_i && !busy_i) |=> !full_i);

  assert_slave_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && ss_ext_ni && $past(ss_ext_ni) && $past(ss_ext_ni, 2)
     && $past(ss_ext_ni, 3)) |-> !busy_i);
endmodule

bind spi_port spi_port_chk i_spi_port_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .master_i (ctrl_q.master),
  .busy_i   (busy_o),
  .full_i   (full_o),
  .buf_re_i (buf_re_i),
  .sck_i    (sck_o),
  .ss_n_i   (ss_no),
  .ss_ext_ni(ss_ni)
);

// File: tb/test_spi_port.sv
module test_spi_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [4:0] ctrl_wdata = '0;
  logic       buf_we = 1'b0;
  logic [7:0] buf_wdata = '0;
  logic       buf_re = 1'b0;
  logic [7:0] buf_rdata;
  logic       full_o, busy_o, sck_o, sck_oe_o, ss_no, sdo_o, sdo_oe_o;
  logic       sdi_i;

  // bench peers
  logic       tb_master = 1'b1;
  logic       bs_sdi = 1'b0, bs_edge = 1'b0, bs_sck_d = 1'b0;
  logic [7:0] bs_tx = '0, bs_cap = '0;
  int         bs_idx = 7;
  logic       bm_sck = 1'b0, bm_ss = 1'b1, bm_sdi = 1'b0;
  logic [7:0] bm_cap = '0;

  int n_chk = 0, n_fail = 0;
  bit full_prev = 1'b0;

  typedef struct { logic [7:0] rx; logic [7:0] tx; bit slave; } item_t;
  item_t exp_q[$];

  assign sdi_i = tb_master ? bs_sdi : bm_sdi;

  always #4 clk = ~clk;

  spi_port i_spi_port (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ctrl_we_i   (ctrl_we),
    .ctrl_wdata_i(ctrl_wdata),
    .buf_we_i    (buf_we),
    .buf_wdata_i (buf_wdata),
    .buf_re_i    (buf_re),
    .buf_rdata_o (buf_rdata),
    .full_o      (full_o),
    .busy_o      (busy_o),
    .sck_o       (sck_o),
    .sck_oe_o    (sck_oe_o),
    .sck_i       (bm_sck),
    .ss_no       (ss_no),
    .ss_ni       (bm_ss),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o),
    .sdi_i       (sdi_i)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bench slave answering the master-mode port
  always @(negedge ss_no or sck_o) begin
    if (sck_o !== bs_sck_d) begin
      bs_sck_d = sck_o;
      if (sck_o == !bs_edge) begin
        bs_cap = {bs_cap[6:0], sdo_o};
        bs_idx--;
      end else if (bs_idx >= 0) begin
        bs_sdi = bs_tx[bs_idx];
      end
    end else begin
      bs_idx = 7;
      bs_sdi = bs_tx[7];
      bs_cap = '0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (full_o && !full_prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected completion", 32'(full_o), 32'h0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(buf_rdata == it.rx, "R3 received byte in buffer", 32'(buf_rdata), 32'(it.rx));
          check((it.slave ? bm_cap : bs_cap) == it.tx, "R2 byte seen by peer, MSB first",
                32'(it.slave ? bm_cap : bs_cap), 32'(it.tx));
        end
      end
      full_prev = full_o;
    end
  end

  task automatic write_ctrl(input bit m, input bit e, input logic [2:0] b);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = {m, e, b};
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic read_buf();
    @(negedge clk); buf_re = 1'b1;
    @(negedge clk); buf_re = 1'b0;
    check(!full_o, "R7 read clears full", 32'(full_o), 32'h0);
  endtask

  task automatic write_buf(input logic [7:0] d);
    @(negedge clk); buf_we = 1'b1; buf_wdata = d;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] rx, input bit e,
                             input logic [2:0] b, input bit poke, input string tag);
    time t1, t2;
    tb_master = 1'b1;
    write_ctrl(1'b1, e, b);
    bs_tx = rx; bs_edge = e;
    exp_q.push_back('{rx, tx, 1'b0});
    write_buf(tx);
    check(busy_o, "R2 busy after start", 32'(busy_o), 32'h1);
    check(!ss_no && sck_oe_o, "R11 select low at start", 32'({ss_no, sck_oe_o}), 32'h1);
    if (poke) begin
      buf_we = 1'b1; buf_wdata = 8'h99;
      @(negedge clk); buf_we = 1'b0;
    end
    @(posedge sck_o); t1 = $time;
    check(!ss_no, "R11 select low on clock", 32'(ss_no), 32'h0);
    @(posedge sck_o); t2 = $time;
    check((t2 - t1) == 64'(8 * (2 << b)), "R4 clock period", 32'(t2 - t1), 32'(8 * (2 << b)));
    while (busy_o) @(negedge clk);
    check(ss_no && !sck_o, "R11 select high after transfer", 32'({ss_no, sck_o}), 32'h2);
    check(full_o, "R3 full set", 32'(full_o), 32'h1);
    check(buf_rdata == rx, tag, 32'(buf_rdata), 32'(rx));
    repeat (5) @(negedge clk);
    check(full_o, "R7 full held until read", 32'(full_o), 32'h1);
    read_buf();
  endtask

  task automatic slave_xfer(input logic [7:0] load, input logic [7:0] tx, input int nbits);
    tb_master = 1'b0;
    write_buf(load);
    bm_cap = '0;
    if (nbits == 8) exp_q.push_back('{tx, load, 1'b1});
    bm_ss = 1'b0;
    #40;
    check(sdo_oe_o, "R9 output driven when selected", 32'(sdo_oe_o), 32'h1);
    for (int i = 0; i < nbits; i++) begin
      bm_sdi = tx[7-i];
      #40 bm_sck = 1'b1;
      bm_cap = {bm_cap[6:0], sdo_o};
      #40 bm_sck = 1'b0;
    end
    #40 bm_ss = 1'b1;
    #1;
    check(!sdo_oe_o, "R9 output released on deselect", 32'(sdo_oe_o), 32'h0);
    #100;
    if (nbits == 8) begin
      check(full_o && buf_rdata == tx, "R8 slave byte received",
            32'({full_o, buf_rdata}), 32'({1'b1, tx}));
      read_buf();
    end else begin
      check(!full_o, "R10 aborted transfer leaves flag clear", 32'(full_o), 32'h0);
      check(buf_rdata == load, "R10 aborted transfer restores byte", 32'(buf_rdata), 32'(load));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(buf_rdata == 8'h00 && !full_o && !busy_o, "R1 reset buffer/flags",
          32'({buf_rdata, full_o, busy_o}), 32'h0);
    check(ss_no && !sck_o && !sck_oe_o && !sdo_oe_o, "R1 reset pins",
          32'({ss_no, sck_o, sck_oe_o, sdo_oe_o}), 32'h8);

    master_xfer(8'hA5, 8'h3C, 1'b0, 3'd0, 1'b0, "R5 edge-select 0 exchange");
    master_xfer(8'h81, 8'h7E, 1'b1, 3'd2, 1'b0, "R5 edge-select 1 exchange");
    master_xfer(8'h0F, 8'hF0, 1'b0, 3'd7, 1'b0, "R4 slowest rate exchange");
    master_xfer(8'hC3, 8'h5A, 1'b0, 3'd1, 1'b1, "R6 write during transfer ignored");

    // slave mode with edge bit and rate set: no effect (R8)
    write_ctrl(1'b0, 1'b1, 3'd5);
    check(!sck_oe_o, "R8 clock not driven in slave mode", 32'(sck_oe_o), 32'h0);
    slave_xfer(8'h6D, 8'hB2, 8);

    // R9 activity while deselected is ignored
    tb_master = 1'b0;
    write_buf(8'h44);
    for (int i = 0; i < 8; i++) begin
      bm_sdi = i[0];
      #40 bm_sck = 1'b1;
      #40 bm_sck = 1'b0;
    end
    #100;
    check(buf_rdata == 8'h44 && !full_o && !sdo_oe_o, "R9 deselected clocks ignored",
          32'({buf_rdata, full_o, sdo_oe_o}), 32'({8'h44, 2'b00}));

    slave_xfer(8'h27, 8'hD8, 4);   // R10 abort
    slave_xfer(8'hE1, 8'h1E, 8);   // R8 normal after abort

    check(exp_q.size() == 0, "R3 all transfers completed", 32'(exp_q.size()), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule